// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register File

This block holds the machine-level interrupt enable, interrupt pending, interrupt delegation and exception delegation registers of a processor core. It also offers supervisor views of the enable and pending registers. These views are filtered by the interrupt delegation register. Trap-entry and priority logic elsewhere in the core read all four registers as plain outputs.

Software reaches the registers through a single access port. An access carries a register select, a write value and a write mask. Only the bits set in the mask take the write value. The read value is the register content from before the access, so one access is a full read-modify-write. Three pending bits are not written by software: machine timer, machine external and supervisor external. They are copied from hardware request lines on every clock edge.

Top module: `irq_deleg_regs`

## Requirements
- R1: In the interrupt delegation register, only bits 1, 5 and 9 can be set. All other bits always read 0.
- R2: In the enable register, only bits 1, 3, 5, 7, 9 and 11 can be set. All other bits always read 0.
- R3: Select 4 (supervisor enable) reads enable AND interrupt delegation. A write through it changes only the enable bits that are delegated, and leaves every other enable bit as it was.
- R4: A software write to pending (select 1) can change only bit 1 and bit 5. Bit 3 always reads 0, and bit 9 is never changed by software.
- R5: Pending bits 7, 9 and 11 equal hwMtip, hwSeip and hwMeip as sampled at the previous clock edge. This holds whatever software writes in that cycle.
- R6: In the exception delegation register, bits 0 to 13 and bit 15 can be set. Bit 14 and bits 16 and above always read 0.
- R7: Select 5 (supervisor pending) reads pending AND interrupt delegation. Its write mask is further ANDed with the interrupt delegation register before the R4 rule applies.
- R8: A write changes only the bits set in accWmask. rdData during an access shows the value from before that access. When accEn is low or the mask is zero, no register changes.
- R9: Selects 6 and 7 read 0, and writes to them change no register.
- R10: After reset, all four registers read 0.

Select encoding: 0 enable, 1 pending, 2 interrupt delegation, 3 exception delegation, 4 supervisor enable, 5 supervisor pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accEn | input | 1 | Write strobe for the access port |
| accSel | input | 3 | Register select |
| accWdata | input | XLEN | Write value |
| accWmask | input | XLEN | Per-bit write mask |
| rdData | output | XLEN | Content of the selected register before the access |
| hwMtip | input | 1 | Machine timer request |
| hwSeip | input | 1 | Supervisor external request |
| hwMeip | input | 1 | Machine external request |
| irqEnable | output | XLEN | Enable register |
| irqPending | output | XLEN | Pending register |
| irqDeleg | output | XLEN | Interrupt delegation register |
| excDeleg | output | XLEN | Exception delegation register |

## Verification
Each register is written in three ways: with all ones under a full mask, with zeros under a partial mask, and with an empty mask. The first separates the legal bit sets from illegal ones. The second shows that bits outside the mask are kept. The supervisor views are tried under a delegation value that covers only some of the bits, so a view that ignores delegation gives a different result from a correct one. The hardware request lines are changed alone, and also while software writes the same pending bits. This shows both the one-cycle lag and that hardware takes precedence over software.

// File: rtl/irq_deleg_pkg.sv
package irq_deleg_pkg;
  // Interrupt bit positions; trap logic decodes these positions
  localparam int SSIP_BIT = 1;
  localparam int MSIP_BIT = 3;
  localparam int STIP_BIT = 5;
  localparam int MTIP_BIT = 7;
  localparam int SEIP_BIT = 9;
  localparam int MEIP_BIT = 11;
  localparam int NUM_EXC  = 16;
  localparam int RSVD_EXC = 14;

  localparam logic [15:0] INT_SUP = (16'(1) << SSIP_BIT) | (16'(1) << STIP_BIT) | (16'(1) << SEIP_BIT);
  localparam logic [15:0] INT_MCH = (16'(1) << MSIP_BIT) | (16'(1) << MTIP_BIT) | (16'(1) << MEIP_BIT);
  localparam logic [15:0] INT_ALL = INT_SUP | INT_MCH;
  localparam logic [15:0] INT_HW  = (16'(1) << MTIP_BIT) | (16'(1) << SEIP_BIT) | (16'(1) << MEIP_BIT);
  localparam logic [15:0] INT_SW  = INT_SUP & ~(16'(1) << SEIP_BIT);
  localparam logic [15:0] EXC_DLG = 16'hFFFF & ~(16'(1) << RSVD_EXC);

  typedef enum logic [2:0] {
    SEL_IEN    = 3'd0,
    SEL_IPEND  = 3'd1,
    SEL_IDLG   = 3'd2,
    SEL_EDLG   = 3'd3,
    SEL_SIEN   = 3'd4,
    SEL_SIPEND = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrIen;
    logic wrIpend;
    logic wrIdlg;
    logic wrEdlg;
    logic wrSien;
    logic wrSipend;
  } wrStrobe_t;
endpackage

// File: rtl/irq_deleg_ctrl.sv
module irq_deleg_ctrl
  import irq_deleg_pkg::*;
(
  input  logic       accEn,
  input  logic [2:0] accSel,
  output wrStrobe_t  wrStb
);
  always_comb begin
    wrStb = '0;
    if (accEn) begin
      case (accSel)
        SEL_IEN:    wrStb.wrIen    = 1'b1;
        SEL_IPEND:  wrStb.wrIpend  = 1'b1;
        SEL_IDLG:   wrStb.wrIdlg   = 1'b1;
        SEL_EDLG:   wrStb.wrEdlg   = 1'b1;
        SEL_SIEN:   wrStb.wrSien   = 1'b1;
        SEL_SIPEND: wrStb.wrSipend = 1'b1;
        default:    wrStb = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_deleg_dp.sv
module irq_deleg_dp
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobe_t       wrStb,
  input  logic [2:0]      rdSel,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] wmask,
  input  logic            hwMtip,
  input  logic            hwSeip,
  input  logic            hwMeip,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] ienQ,
  output logic [XLEN-1:0] ipendQ,
  output logic [XLEN-1:0] idlgQ,
  output logic [XLEN-1:0] edlgQ
);
  localparam logic [XLEN-1:0] IEN_M  = XLEN'(INT_ALL);
  localparam logic [XLEN-1:0] IDLG_M = XLEN'(INT_SUP);
  localparam logic [XLEN-1:0] SWP_M  = XLEN'(INT_SW);
  localparam logic [XLEN-1:0] HWP_M  = XLEN'(INT_HW);
  localparam logic [XLEN-1:0] EDLG_M = XLEN'(EXC_DLG);

  function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] cur,
                                            input logic [XLEN-1:0] val,
                                            input logic [XLEN-1:0] m);
    return (cur & ~m) | (val & m);
  endfunction

  logic [XLEN-1:0] ienEff, pendEff, idlgEff, edlgEff;
  logic [XLEN-1:0] ienD, ipendD, idlgD, edlgD, hwVec, pendSw;

  always_comb begin
    ienEff  = wrStb.wrIen    ? (wmask & IEN_M)
            : wrStb.wrSien   ? (wmask & idlgQ & IEN_M) : '0;
    pendEff = wrStb.wrIpend  ? (wmask & SWP_M)
            : wrStb.wrSipend ? (wmask & idlgQ & SWP_M) : '0;
    idlgEff = wrStb.wrIdlg ? (wmask & IDLG_M) : '0;
    edlgEff = wrStb.wrEdlg ? (wmask & EDLG_M) : '0;

    hwVec = '0;
    hwVec[MTIP_BIT] = hwMtip;
    hwVec[SEIP_BIT] = hwSeip;
    hwVec[MEIP_BIT] = hwMeip;

    ienD   = merge(ienQ, wdata, ienEff);
    pendSw = merge(ipendQ, wdata, pendEff);
    ipendD = (pendSw & ~HWP_M) | hwVec;
    idlgD  = merge(idlgQ, wdata, idlgEff);
    edlgD  = merge(edlgQ, wdata, edlgEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienQ   <= '0;
      ipendQ <= '0;
      idlgQ  <= '0;
      edlgQ  <= '0;
    end else begin
      ienQ   <= ienD;
      ipendQ <= ipendD;
      idlgQ  <= idlgD;
      edlgQ  <= edlgD;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_IEN:    rdData = ienQ;
      SEL_IPEND:  rdData = ipendQ;
      SEL_IDLG:   rdData = idlgQ;
      SEL_EDLG:   rdData = edlgQ;
      SEL_SIEN:   rdData = ienQ & idlgQ;
      SEL_SIPEND: rdData = ipendQ & idlgQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_deleg_regs.sv
module irq_deleg_regs
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accEn,
  input  logic [2:0]      accSel,
  input  logic [XLEN-1:0] accWdata,
  input  logic [XLEN-1:0] accWmask,
  output logic [XLEN-1:0] rdData,
  input  logic            hwMtip,
  input  logic            hwSeip,
  input  logic            hwMeip,
  output logic [XLEN-1:0] irqEnable,
  output logic [XLEN-1:0] irqPending,
  output logic [XLEN-1:0] irqDeleg,
  output logic [XLEN-1:0] excDeleg
);
  wrStrobe_t wrStb;

  irq_deleg_ctrl u_ctrl (
    .accEn  (accEn),
    .accSel (accSel),
    .wrStb  (wrStb)
  );

  irq_deleg_dp #(.XLEN(XLEN)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .rdSel  (accSel),
    .wdata  (accWdata),
    .wmask  (accWmask),
    .hwMtip (hwMtip),
    .hwSeip (hwSeip),
    .hwMeip (hwMeip),
    .rdData (rdData),
    .ienQ   (irqEnable),
    .ipendQ (irqPending),
    .idlgQ  (irqDeleg),
    .edlgQ  (excDeleg)
  );
endmodule

// File: rtl/irq_deleg_chk.sv
module irq_deleg_chk
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            accEn,
  input logic [2:0]      accSel,
  input logic            hwSeip,
  input logic [XLEN-1:0] irqEnable,
  input logic [XLEN-1:0] irqPending,
  input logic [XLEN-1:0] irqDeleg,
  input logic [XLEN-1:0] excDeleg
);
  localparam logic [XLEN-1:0] IEN_M  = XLEN'(INT_ALL);
  localparam logic [XLEN-1:0] IDLG_M = XLEN'(INT_SUP);
  localparam logic [XLEN-1:0] EDLG_M = XLEN'(EXC_DLG);

  AST_IDLG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (irqDeleg & ~IDLG_M) == '0); // R1
  AST_IEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable & ~IEN_M) == '0); // R2
  AST_SIEN_KEEPS_UNDELEG: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accSel == 3'd4) |=> ((irqEnable ^ $past(irqEnable)) & ~$past(irqDeleg)) == '0); // R3
  AST_MSIP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    irqPending[MSIP_BIT] == 1'b0); // R4
  AST_SEIP_FROM_HW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> irqPending[SEIP_BIT] == $past(hwSeip)); // R5
  AST_EDLG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (excDeleg & ~EDLG_M) == '0); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |=> ($stable(irqEnable) && $stable(irqDeleg) && $stable(excDeleg))); // R8
  AST_UNUSED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accSel > 3'd5) |=> ($stable(irqEnable) && $stable(irqDeleg) && $stable(excDeleg))); // R9
endmodule

bind irq_deleg_regs irq_deleg_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .accEn      (accEn),
  .accSel     (accSel),
  .hwSeip     (hwSeip),
  .irqEnable  (irqEnable),
  .irqPending (irqPending),
  .irqDeleg   (irqDeleg),
  .excDeleg   (excDeleg)
);

// File: tb/tb_irq_deleg_regs.sv
module tb_irq_deleg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accEn = 1'b0;
  logic [2:0] accSel = 3'd0;
  logic [31:0] accWdata = '0, accWmask = '0;
  logic hwMtip = 1'b0, hwSeip = 1'b0, hwMeip = 1'b0;
  logic [31:0] rdData, irqEnable, irqPending, irqDeleg, excDeleg;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_deleg_regs #(.XLEN(XLEN)) dut (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accSel(accSel),
    .accWdata(accWdata), .accWmask(accWmask), .rdData(rdData),
    .hwMtip(hwMtip), .hwSeip(hwSeip), .hwMeip(hwMeip),
    .irqEnable(irqEnable), .irqPending(irqPending),
    .irqDeleg(irqDeleg), .excDeleg(excDeleg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; accEn = 1'b0; hwMtip = 0; hwSeip = 0; hwMeip = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic acc(input logic [2:0] sel, input logic [31:0] wd,
                     input logic [31:0] wm, output logic [31:0] old);
    @(negedge clk);
    accEn = 1'b1; accSel = sel; accWdata = wd; accWmask = wm;
    #1 old = rdData;
    @(negedge clk);
    accEn = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R10 enable", irqEnable, 0);
    chk("R10 pending", irqPending, 0);
    chk("R10 ideleg", irqDeleg, 0);
    chk("R10 edeleg", excDeleg, 0);
    for (int s = 0; s < 8; s++) begin
      accSel = 3'(s); #1;
      chk("R10 read", rdData, 0);
    end
  endtask

  task automatic t_enable();
    logic [31:0] o;
    doReset();
    acc(0, ONES, ONES, o);
    chk("R8 old value", o, 0);
    chk("R2 legal bits", irqEnable, 32'h0000_0AAA);
    acc(0, 0, 32'h0000_000F, o);
    chk("R8 partial mask", irqEnable, 32'h0000_0AA0);
    acc(0, 0, 0, o);
    chk("R8 old value", o, 32'h0000_0AA0);
    chk("R8 empty mask", irqEnable, 32'h0000_0AA0);
  endtask

  task automatic t_ideleg();
    logic [31:0] o;
    doReset();
    acc(2, ONES, ONES, o);
    chk("R1 legal bits", irqDeleg, 32'h0000_0222);
    acc(2, 0, 32'h2, o);
    chk("R1 partial clear", irqDeleg, 32'h0000_0220);
  endtask

  task automatic t_edeleg();
    logic [31:0] o;
    doReset();
    acc(3, ONES, ONES, o);
    chk("R6 legal bits", excDeleg, 32'h0000_BFFF);
    acc(3, 0, 32'h0000_8000, o);
    chk("R6 clear bit 15", excDeleg, 32'h0000_3FFF);
  endtask

  task automatic t_sien();
    logic [31:0] o;
    doReset();
    acc(0, ONES, ONES, o);
    acc(2, 32'h0000_0020, ONES, o);
    acc(4, 0, ONES, o);
    chk("R3 view read", o, 32'h0000_0020);
    chk("R3 clear delegated only", irqEnable, 32'h0000_0A8A);
    acc(4, ONES, ONES, o);
    chk("R3 set delegated only", irqEnable, 32'h0000_0AAA);
  endtask

  task automatic t_pend();
    logic [31:0] o;
    doReset();
    acc(1, ONES, ONES, o);
    chk("R4 software bits", irqPending, 32'h0000_0022);
    acc(1, 0, ONES, o);
    chk("R8 pending old", o, 32'h0000_0022);
    chk("R4 software clear", irqPending, 0);
    hwSeip = 1'b1;
    @(negedge clk);
    acc(1, 0, ONES, o);
    chk("R4 supervisor external kept", irqPending, 32'h0000_0200);
    @(negedge clk);
    hwSeip = 1'b0;
    acc(1, ONES, ONES, o);
    chk("R5 hardware over software", irqPending, 32'h0000_0022);
  endtask

  task automatic t_hw();
    doReset();
    @(negedge clk);
    hwMtip = 1'b1; hwMeip = 1'b1;
    #1 chk("R5 one cycle lag", irqPending, 0);
    @(negedge clk);
    chk("R5 machine requests", irqPending, 32'h0000_0880);
    hwMtip = 1'b0; hwMeip = 1'b0;
    @(negedge clk);
    chk("R5 requests drop", irqPending, 0);
  endtask

  task automatic t_sipend();
    logic [31:0] o;
    doReset();
    acc(2, 32'h0000_0020, ONES, o);
    acc(1, ONES, ONES, o);
    acc(5, 0, ONES, o);
    chk("R7 view read", o, 32'h0000_0020);
    chk("R7 clear delegated only", irqPending, 32'h0000_0002);
    acc(5, ONES, ONES, o);
    chk("R7 set delegated only", irqPending, 32'h0000_0022);
  endtask

  task automatic t_unused();
    logic [31:0] o;
    doReset();
    acc(0, ONES, ONES, o);
    acc(6, ONES, ONES, o);
    chk("R9 select 6 reads zero", o, 0);
    acc(7, ONES, ONES, o);
    chk("R9 select 7 reads zero", o, 0);
    chk("R9 enable kept", irqEnable, 32'h0000_0AAA);
    chk("R9 pending kept", irqPending, 0);
    chk("R9 ideleg kept", irqDeleg, 0);
    chk("R9 edeleg kept", excDeleg, 0);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_ideleg();
    t_edeleg();
    t_sien();
    t_pend();
    t_hw();
    t_sipend();
    t_unused();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule